// File: doc/BRIEF.md
# Cache Maintenance Command Decoder

This block sits between the coprocessor access path of a processor core and the engines that actually do cache, predictor, translation and barrier work. Each cycle it may receive one access to the cache-maintenance register group. An access is described by a 4-bit CRm selector, a 3-bit opcode2 selector, a read/write flag, a privilege flag, a secure-state flag and a 32-bit data word. One cycle later it emits either a single one-hot request strobe, together with a cleaned-up operand, or an undefined-instruction exception pulse. It may also emit nothing, when a set/way operand names a cache level that is not built.

The operand is shaped to suit the operation. Line-address operations get the data word with the offset bits inside the line cleared. Set/way operations keep only the way, set and level fields, and the field widths depend on the level that is selected. Operations that take no data get zero. Translation requests and result-register writes get the word unchanged.

Every encoding is checked for read legality, privilege and security state before any strobe is raised. The line size, the L1 and L2 way and set widths, and whether an L2 is present at all (L2 set width zero) are parameters.

Top module: `cmo_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, `cmd_req_o`, `cmd_operand_o`, `cmd_xmode_o` and `undef_o` are zero after that edge.
- R2: A privileged write with CRm 5 raises the following bits of `cmd_req_o`: opcode2 0 raises bit 0 (invalidate all instruction caches and the branch target cache), opcode2 1 raises bit 1 (instruction line by address), opcode2 4 raises bit 2 (prefetch flush), opcode2 6 raises bit 3 (whole branch predictor) and opcode2 7 raises bit 4 (one predictor entry by address).
- R3: Privileged writes to the data-line operations raise the following bits of `cmd_req_o`. CRm 6 opcode2 1 raises bit 5 and opcode2 2 raises bit 6 (invalidate). CRm 10 opcode2 1 raises bit 7 and opcode2 2 raises bit 8 (clean). CRm 11 opcode2 1 raises bit 9 (clean to point of unification). CRm 14 opcode2 1 raises bit 10 and opcode2 2 raises bit 11 (clean and invalidate). Opcode2 1 takes an address operand and opcode2 2 takes a set/way operand.
- R4: A read raises `undef_o` unless it targets CRm 4 / opcode2 0. A privileged read of that encoding raises bit 16 with a zero operand, and a privileged write to it raises bit 17 with the data word as the operand.
- R5: With `acc_priv_i` low, only writes of the data synchronization barrier (CRm 10 opcode2 4, bit 12), the data memory barrier (CRm 10 opcode2 5, bit 13) and prefetch flush (CRm 5 opcode2 4, bit 2) produce a strobe. Every other user-mode access raises `undef_o`. In privileged mode these three encodings behave the same way.
- R6: Address operands equal the data word with bits [5:0] cleared. Operations without data (bits 0, 2, 3, 12, 13, 16) carry a zero operand. Translation requests and result-register writes carry the data word unchanged.
- R7: A set/way operand keeps bits [3:1] (level, where 0 means L1) and clears all other reserved bits. For level 0 it also keeps the top 2 bits as the way and bits [12:6] as the set. For level 1 it keeps the top 3 bits as the way and bits [14:6] as the set.
- R8: CRm 8 writes are translation requests whose `cmd_xmode_o` equals opcode2[1:0]. Opcode2 0-3 raise bit 14 when privileged. Opcode2 4-7 raise bit 15 only when the access is both privileged and secure, and otherwise raise `undef_o`.
- R9: Any encoding not named in R2-R8 raises `undef_o`.
- R10: A set/way operation whose level field selects a cache level that is not built (level 2 or above, or level 1 when the L2 set width is zero) produces neither a strobe nor `undef_o`.
- R11: Outputs follow the access by exactly one cycle and last one cycle. A cycle without `acc_valid_i` produces nothing, and at most one of the `cmd_req_o` bits and `undef_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid_i | input | 1 | An access is presented this cycle |
| acc_crm_i | input | 4 | CRm selector |
| acc_op2_i | input | 3 | Opcode2 selector |
| acc_read_i | input | 1 | 1 = read, 0 = write |
| acc_priv_i | input | 1 | 1 = privileged mode |
| acc_secure_i | input | 1 | 1 = secure state |
| acc_data_i | input | 32 | Data word written with the access |
| cmd_req_o | output | 18 | One-hot operation request strobe |
| cmd_operand_o | output | 32 | Shaped operand for the strobed operation |
| cmd_xmode_o | output | 2 | Permission selector for translation requests |
| undef_o | output | 1 | Undefined-instruction exception pulse |

## Verification
The bench sweeps every CRm/opcode2 pair under all eight combinations of read, privilege and security state. A decoder that let a non-barrier operation through in user mode, or that accepted a read anywhere except the result register, would strobe a command where an exception is expected. Other-state translations issued from the non-secure side are a separate case, because they are privileged but still illegal, and a decoder that checked only privilege would accept them. Set/way operands are driven with all level values and with every bit set, so that a wrong field width, a reserved bit left set, or a missing drop of a level that is not built all show up at the operand or strobe outputs. Long runs of back-to-back and gapped accesses expose any strobe that lasts more than one cycle or fires without a valid access.

// File: rtl/cmo_pkg.sv
package cmo_pkg;
  localparam int NUM_OPS = 18;
  localparam int WORD_W  = 32;

  typedef enum logic [4:0] {
    OP_IC_INV_ALL    = 5'd0,
    OP_IC_INV_LINE   = 5'd1,
    OP_PF_FLUSH      = 5'd2,
    OP_BP_INV_ALL    = 5'd3,
    OP_BP_INV_LINE   = 5'd4,
    OP_DC_INV_LINE   = 5'd5,
    OP_DC_INV_SW     = 5'd6,
    OP_DC_CLEAN_LINE = 5'd7,
    OP_DC_CLEAN_SW   = 5'd8,
    OP_DC_CLEAN_PU   = 5'd9,
    OP_DC_CI_LINE    = 5'd10,
    OP_DC_CI_SW      = 5'd11,
    OP_SYNC_BARRIER  = 5'd12,
    OP_MEM_BARRIER   = 5'd13,
    OP_XLATE_CUR     = 5'd14,
    OP_XLATE_OTHER   = 5'd15,
    OP_RESULT_RD     = 5'd16,
    OP_RESULT_WR     = 5'd17
  } cmo_op_e;

  typedef enum logic [1:0] {
    OPD_ZERO   = 2'd0,
    OPD_ADDR   = 2'd1,
    OPD_SETWAY = 2'd2,
    OPD_RAW    = 2'd3
  } opd_kind_e;

  typedef struct packed {
    logic      known;
    cmo_op_e   op;
    opd_kind_e kind;
    logic      user_ok;
    logic      secure_only;
  } dec_info_t;

  function automatic dec_info_t mk_info(cmo_op_e op, opd_kind_e kind,
                                        logic user_ok, logic secure_only);
    dec_info_t r;
    r.known       = 1'b1;
    r.op          = op;
    r.kind        = kind;
    r.user_ok     = user_ok;
    r.secure_only = secure_only;
    return r;
  endfunction
endpackage

// File: rtl/cmo_enc_decode.sv
module cmo_enc_decode
  import cmo_pkg::*;
(
  input  logic [3:0] crm_i,
  input  logic [2:0] op2_i,
  input  logic       is_read_i,
  output dec_info_t  info_o
);
  always_comb begin
    info_o = '{known: 1'b0, op: OP_IC_INV_ALL, kind: OPD_ZERO,
               user_ok: 1'b0, secure_only: 1'b0};
    if (is_read_i) begin
      if (crm_i == 4'd4 && op2_i == 3'd0)
        info_o = mk_info(OP_RESULT_RD, OPD_ZERO, 1'b0, 1'b0);
    end else begin
      case (crm_i)
        4'd4: if (op2_i == 3'd0) info_o = mk_info(OP_RESULT_WR, OPD_RAW, 1'b0, 1'b0);
        4'd5: begin
          case (op2_i)
            3'd0: info_o = mk_info(OP_IC_INV_ALL,  OPD_ZERO, 1'b0, 1'b0);
            3'd1: info_o = mk_info(OP_IC_INV_LINE, OPD_ADDR, 1'b0, 1'b0);
            3'd4: info_o = mk_info(OP_PF_FLUSH,    OPD_ZERO, 1'b1, 1'b0);
            3'd6: info_o = mk_info(OP_BP_INV_ALL,  OPD_ZERO, 1'b0, 1'b0);
            3'd7: info_o = mk_info(OP_BP_INV_LINE, OPD_ADDR, 1'b0, 1'b0);
            default: ;
          endcase
        end
        4'd6: begin
          if (op2_i == 3'd1) info_o = mk_info(OP_DC_INV_LINE, OPD_ADDR,   1'b0, 1'b0);
          if (op2_i == 3'd2) info_o = mk_info(OP_DC_INV_SW,   OPD_SETWAY, 1'b0, 1'b0);
        end
        4'd8: info_o = mk_info(op2_i[2] ? OP_XLATE_OTHER : OP_XLATE_CUR, OPD_RAW,
                               1'b0, op2_i[2]);
        4'd10: begin
          case (op2_i)
            3'd1: info_o = mk_info(OP_DC_CLEAN_LINE, OPD_ADDR,   1'b0, 1'b0);
            3'd2: info_o = mk_info(OP_DC_CLEAN_SW,   OPD_SETWAY, 1'b0, 1'b0);
            3'd4: info_o = mk_info(OP_SYNC_BARRIER,  OPD_ZERO,   1'b1, 1'b0);
            3'd5: info_o = mk_info(OP_MEM_BARRIER,   OPD_ZERO,   1'b1, 1'b0);
            default: ;
          endcase
        end
        4'd11: if (op2_i == 3'd1) info_o = mk_info(OP_DC_CLEAN_PU, OPD_ADDR, 1'b0, 1'b0);
        4'd14: begin
          if (op2_i == 3'd1) info_o = mk_info(OP_DC_CI_LINE, OPD_ADDR,   1'b0, 1'b0);
          if (op2_i == 3'd2) info_o = mk_info(OP_DC_CI_SW,   OPD_SETWAY, 1'b0, 1'b0);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cmo_operand_fmt.sv
module cmo_operand_fmt
  import cmo_pkg::*;
#(
  parameter int LINE_BITS   = 6,
  parameter int L1_WAY_BITS = 2,
  parameter int L1_SET_BITS = 7,
  parameter int L2_WAY_BITS = 3,
  parameter int L2_SET_BITS = 9
) (
  input  logic [WORD_W-1:0] data_i,
  input  opd_kind_e         kind_i,
  output logic [WORD_W-1:0] operand_o,
  output logic              level_ok_o
);
  function automatic logic [WORD_W-1:0] sw_mask(int way_bits, int set_bits);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (i >= WORD_W - way_bits) m[i] = 1'b1;
      if (i >= LINE_BITS && i < LINE_BITS + set_bits) m[i] = 1'b1;
      if (i >= 1 && i <= 3) m[i] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [WORD_W-1:0] ADDR_MASK = ~((WORD_W'(1) << LINE_BITS) - WORD_W'(1));
  localparam logic [WORD_W-1:0] L1_MASK   = sw_mask(L1_WAY_BITS, L1_SET_BITS);

  logic [2:0]        lvl;
  logic              l2_hit;
  logic [WORD_W-1:0] l2_mask;

  assign lvl = data_i[3:1];

  generate
    if (L2_SET_BITS > 0) begin : g_l2
      assign l2_hit  = (lvl == 3'd1);
      assign l2_mask = sw_mask(L2_WAY_BITS, L2_SET_BITS);
    end else begin : g_no_l2
      assign l2_hit  = 1'b0;
      assign l2_mask = '0;
    end
  endgenerate

  always_comb begin
    operand_o  = '0;
    level_ok_o = 1'b1;
    case (kind_i)
      OPD_ADDR: operand_o = data_i & ADDR_MASK;
      OPD_RAW:  operand_o = data_i;
      OPD_SETWAY: begin
        if (lvl == 3'd0)  operand_o = data_i & L1_MASK;
        else if (l2_hit)  operand_o = data_i & l2_mask;
        else              level_ok_o = 1'b0;
      end
      default: operand_o = '0;
    endcase
  end
endmodule

// File: rtl/cmo_access_check.sv
module cmo_access_check
  import cmo_pkg::*;
(
  input  logic      valid_i,
  input  dec_info_t info_i,
  input  logic      priv_i,
  input  logic      secure_i,
  input  logic      level_ok_i,
  output logic      fire_cmd_o,
  output logic      fire_undef_o
);
  logic deny;

  always_comb begin
    deny = !info_i.known
        || (!priv_i && !info_i.user_ok)
        || (info_i.secure_only && !secure_i);
    fire_undef_o = valid_i && deny;
    fire_cmd_o   = valid_i && !deny && level_ok_i;
  end
endmodule

// File: rtl/cmo_decoder.sv
module cmo_decoder
  import cmo_pkg::*;
#(
  parameter int LINE_BITS   = 6,
  parameter int L1_WAY_BITS = 2,
  parameter int L1_SET_BITS = 7,
  parameter int L2_WAY_BITS = 3,
  parameter int L2_SET_BITS = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc_valid_i,
  input  logic [3:0]         acc_crm_i,
  input  logic [2:0]         acc_op2_i,
  input  logic               acc_read_i,
  input  logic               acc_priv_i,
  input  logic               acc_secure_i,
  input  logic [WORD_W-1:0]  acc_data_i,
  output logic [NUM_OPS-1:0] cmd_req_o,
  output logic [WORD_W-1:0]  cmd_operand_o,
  output logic [1:0]         cmd_xmode_o,
  output logic               undef_o
);
  dec_info_t         info;
  logic [WORD_W-1:0] operand;
  logic              level_ok;
  logic              fire_cmd;
  logic              fire_undef;
  logic              is_xlate;

  cmo_enc_decode u_dec (
    .crm_i     (acc_crm_i),
    .op2_i     (acc_op2_i),
    .is_read_i (acc_read_i),
    .info_o    (info)
  );

  cmo_operand_fmt #(
    .LINE_BITS   (LINE_BITS),
    .L1_WAY_BITS (L1_WAY_BITS),
    .L1_SET_BITS (L1_SET_BITS),
    .L2_WAY_BITS (L2_WAY_BITS),
    .L2_SET_BITS (L2_SET_BITS)
  ) u_fmt (
    .data_i     (acc_data_i),
    .kind_i     (info.kind),
    .operand_o  (operand),
    .level_ok_o (level_ok)
  );

  cmo_access_check u_chk_acc (
    .valid_i      (acc_valid_i),
    .info_i       (info),
    .priv_i       (acc_priv_i),
    .secure_i     (acc_secure_i),
    .level_ok_i   (level_ok),
    .fire_cmd_o   (fire_cmd),
    .fire_undef_o (fire_undef)
  );

  assign is_xlate = (info.op == OP_XLATE_CUR) || (info.op == OP_XLATE_OTHER);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_req_o     <= '0;
      cmd_operand_o <= '0;
      cmd_xmode_o   <= '0;
      undef_o       <= 1'b0;
    end else begin
      cmd_req_o     <= '0;
      cmd_operand_o <= '0;
      cmd_xmode_o   <= '0;
      undef_o       <= fire_undef;
      if (fire_cmd) begin
        cmd_req_o[info.op] <= 1'b1;
        cmd_operand_o      <= operand;
        cmd_xmode_o        <= is_xlate ? acc_op2_i[1:0] : 2'd0;
      end
    end
  end
endmodule

// File: rtl/cmo_decoder_chk.sv
module cmo_decoder_chk
  import cmo_pkg::*;
#(
  parameter int LINE_BITS = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               acc_valid_i,
  input logic [3:0]         acc_crm_i,
  input logic [2:0]         acc_op2_i,
  input logic               acc_read_i,
  input logic               acc_priv_i,
  input logic               acc_secure_i,
  input logic [NUM_OPS-1:0] cmd_req_o,
  input logic [WORD_W-1:0]  cmd_operand_o,
  input logic               undef_o
);
  logic user_legal;
  logic addr_op;

  assign user_legal = (acc_crm_i == 4'd10 && (acc_op2_i == 3'd4 || acc_op2_i == 3'd5))
                   || (acc_crm_i == 4'd5 && acc_op2_i == 3'd4);
  assign addr_op = cmd_req_o[OP_IC_INV_LINE] | cmd_req_o[OP_BP_INV_LINE]
                 | cmd_req_o[OP_DC_INV_LINE] | cmd_req_o[OP_DC_CLEAN_LINE]
                 | cmd_req_o[OP_DC_CLEAN_PU] | cmd_req_o[OP_DC_CI_LINE];

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (cmd_req_o == '0 && !undef_o)); // R1

  AST_READ_UNDEF: assert property (@(posedge clk) disable iff (rst)
    acc_valid_i && acc_read_i && !(acc_crm_i == 4'd4 && acc_op2_i == 3'd0) |=> undef_o); // R4

  AST_USER_GATE: assert property (@(posedge clk) disable iff (rst)
    acc_valid_i && !acc_priv_i && !user_legal |=> undef_o); // R5

  AST_LINE_ALIGN: assert property (@(posedge clk) disable iff (rst)
    addr_op |-> cmd_operand_o[LINE_BITS-1:0] == '0); // R6

  AST_OTHER_STATE: assert property (@(posedge clk) disable iff (rst)
    acc_valid_i && !acc_secure_i && acc_crm_i == 4'd8 && acc_op2_i[2] |=> undef_o); // R8

  AST_SINGLE_EVENT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_req_o, undef_o})); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !acc_valid_i |=> (cmd_req_o == '0 && !undef_o)); // R11
endmodule

bind cmo_decoder cmo_decoder_chk #(.LINE_BITS(LINE_BITS)) u_cmo_chk (
  .clk           (clk),
  .rst           (rst),
  .acc_valid_i   (acc_valid_i),
  .acc_crm_i     (acc_crm_i),
  .acc_op2_i     (acc_op2_i),
  .acc_read_i    (acc_read_i),
  .acc_priv_i    (acc_priv_i),
  .acc_secure_i  (acc_secure_i),
  .cmd_req_o     (cmd_req_o),
  .cmd_operand_o (cmd_operand_o),
  .undef_o       (undef_o)
);

// File: tb/cmo_decoder_bench.sv
module cmo_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid_i = 1'b0;
  logic [3:0]  acc_crm_i = '0;
  logic [2:0]  acc_op2_i = '0;
  logic        acc_read_i = 1'b0;
  logic        acc_priv_i = 1'b0;
  logic        acc_secure_i = 1'b0;
  logic [31:0] acc_data_i = '0;
  logic [17:0] cmd_req_o;
  logic [31:0] cmd_operand_o;
  logic [1:0]  cmd_xmode_o;
  logic        undef_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  int unsigned seed = 32'h1234_5678;

  always #5 clk = ~clk;

  cmo_decoder u_cmo_decoder (
    .clk (clk), .rst (rst), .acc_valid_i (acc_valid_i), .acc_crm_i (acc_crm_i),
    .acc_op2_i (acc_op2_i), .acc_read_i (acc_read_i), .acc_priv_i (acc_priv_i),
    .acc_secure_i (acc_secure_i), .acc_data_i (acc_data_i), .cmd_req_o (cmd_req_o),
    .cmd_operand_o (cmd_operand_o), .cmd_xmode_o (cmd_xmode_o), .undef_o (undef_o)
  );

  function automatic int unsigned next_rand();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  function automatic logic [31:0] keep_mask(int way_bits, int set_bits);
    logic [31:0] m = '0;
    for (int i = 0; i < 32; i++)
      if (i >= 32 - way_bits || (i >= 6 && i < 6 + set_bits) || (i >= 1 && i <= 3)) m[i] = 1'b1;
    return m;
  endfunction

  // Behavioural expectation built from the requirement text
  task automatic model(input bit v, input int crm, input int op2, input bit rd,
                       input bit pr, input bit sc, input logic [31:0] d,
                       output logic [17:0] e_cmd, output logic [31:0] e_opd,
                       output logic [1:0] e_xm, output bit e_und,
                       output string tag, output string otag);
    int op = -1;
    int kind = 0; // 0 none, 1 address, 2 set/way, 3 raw
    bit uok = 0;
    e_cmd = '0; e_opd = '0; e_xm = '0; e_und = 0; tag = "R11"; otag = "R6";
    if (!v) return;
    if (rd) begin
      if (crm == 4 && op2 == 0) op = 16;
    end else if (crm == 4 && op2 == 0) begin op = 17; kind = 3; end
    else if (crm == 5) begin
      if (op2 == 0) op = 0;
      if (op2 == 1) begin op = 1; kind = 1; end
      if (op2 == 4) begin op = 2; uok = 1; end
      if (op2 == 6) op = 3;
      if (op2 == 7) begin op = 4; kind = 1; end
    end else if (crm == 6 || crm == 10 || crm == 14) begin
      int base = (crm == 6) ? 5 : (crm == 10) ? 7 : 10;
      if (op2 == 1) begin op = base; kind = 1; end
      if (op2 == 2) begin op = base + 1; kind = 2; end
      if (crm == 10 && op2 == 4) begin op = 12; uok = 1; end
      if (crm == 10 && op2 == 5) begin op = 13; uok = 1; end
    end else if (crm == 11 && op2 == 1) begin op = 9; kind = 1; end
    else if (crm == 8) begin op = (op2 >= 4) ? 15 : 14; kind = 3; end

    if (op < 0) begin e_und = 1; tag = rd ? "R4" : "R9"; return; end
    if (op <= 4) tag = "R2";
    else if (op <= 11) tag = "R3";
    else if (op <= 13) tag = "R5";
    else if (op <= 15) tag = "R8";
    else tag = "R4";
    if (!pr && !uok) begin e_und = 1; tag = "R5"; return; end
    if (op == 15 && !sc) begin e_und = 1; tag = "R8"; return; end
    case (kind)
      1: e_opd = d & 32'hFFFF_FFC0;
      3: e_opd = d;
      2: begin
        otag = "R7";
        if (d[3:1] == 3'd0) e_opd = d & keep_mask(2, 7);
        else if (d[3:1] == 3'd1) e_opd = d & keep_mask(3, 9);
        else begin tag = "R10"; return; end
      end
      default: e_opd = '0;
    endcase
    e_cmd[op] = 1'b1;
    if (op == 14 || op == 15) e_xm = op2[1:0];
  endtask

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Drive at a falling edge, sample at the next falling edge
  task automatic step(input bit v, input int crm, input int op2, input bit rd,
                      input bit pr, input bit sc, input logic [31:0] d);
    logic [17:0] e_cmd; logic [31:0] e_opd; logic [1:0] e_xm; bit e_und;
    string tag, otag;
    model(v, crm, op2, rd, pr, sc, d, e_cmd, e_opd, e_xm, e_und, tag, otag);
    acc_valid_i = v; acc_crm_i = 4'(crm); acc_op2_i = 3'(op2);
    acc_read_i = rd; acc_priv_i = pr; acc_secure_i = sc; acc_data_i = d;
    @(negedge clk);
    check(tag, "cmd_req", 32'(cmd_req_o), 32'(e_cmd));
    check(tag, "undef", 32'(undef_o), 32'(e_und));
    check(otag, "operand", cmd_operand_o, e_opd);
    check("R8", "xmode", 32'(cmd_xmode_o), 32'(e_xm));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R1: reset state with junk on the inputs
    acc_valid_i = 1'b1; acc_crm_i = 4'd5; acc_priv_i = 1'b1; acc_data_i = '1;
    repeat (3) @(negedge clk);
    check("R1", "cmd_req in reset", 32'(cmd_req_o), 32'd0);
    check("R1", "undef in reset", 32'(undef_o), 32'd0);
    check("R1", "operand in reset", cmd_operand_o, 32'd0);
    rst = 1'b0;
    step(0, 5, 0, 0, 1, 1, '1);

    // Full sweep of encodings x read/priv/secure (R2-R9)
    for (int crm = 0; crm < 16; crm++)
      for (int op2 = 0; op2 < 8; op2++)
        for (int a = 0; a < 8; a++)
          step(1, crm, op2, a[2], a[1], a[0], next_rand());

    // R6: address operands with low bits set
    step(1, 5, 1, 0, 1, 0, 32'hDEAD_BEFF);
    step(1, 11, 1, 0, 1, 1, 32'h0000_003F);
    step(1, 5, 0, 0, 1, 1, 32'hFFFF_FFFF);

    // R7 / R10: every level value with all bits set
    for (int lvl = 0; lvl < 8; lvl++) begin
      step(1, 6, 2, 0, 1, 0, 32'hFFFF_FFF1 | 32'(lvl << 1));
      step(1, 14, 2, 0, 1, 1, 32'hFFFF_FFF1 | 32'(lvl << 1));
    end

    // R8: translation from each side
    step(1, 8, 7, 0, 1, 0, 32'h1234_5678);
    step(1, 8, 6, 0, 1, 1, 32'h8765_4321);
    step(1, 8, 3, 0, 1, 0, 32'hCAFE_0001);

    // R11: gapped and back-to-back random traffic
    for (int i = 0; i < 400; i++) begin
      int unsigned r = next_rand();
      step(r[0] | r[1], int'(r[5:2]), int'(r[8:6]), r[9] & r[10], r[11] | r[12],
           r[13], next_rand());
    end
    step(0, 0, 0, 0, 0, 0, '0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule